// File: doc/BRIEF.md
# Sector Cherenkov Coincidence Trigger

This block builds the trigger decision for one detector sector from nine photomultiplier amplitude streams and the sector's calorimeter hit flag. Each cycle it takes one new sample per tube and applies that tube's own gain correction, which is a fixed-point multiply that saturates. It then makes two tests on the corrected values, side by side. The first counts how many tubes lie above a low per-channel threshold and requires a programmable minimum of tubes. The second adds all corrected values and requires the total to lie above a separate, higher threshold. When both tests pass, the sector has a Cherenkov candidate.

The candidate must then fall close in time to a calorimeter hit. The window is programmable in clock ticks, at 4 ns per tick for a 250 MHz sample clock, and it is symmetric, so either signal may arrive first. A match gives a single-cycle trigger pulse. After that pulse a programmable hold-off suppresses further triggers. The tube multiplicity is also output every cycle, so the sector logic can monitor it.

Inputs are sampled on every rising clock edge. All thresholds and settings are static configuration levels.

Top module: `pmt_coinc_trigger`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge shows `trig_o` = 0 and `mult_o` = 0, and no earlier activity survives the reset.
- R2: Channel c's corrected value is floor(sample_c × gain_c / 256). Channel c occupies bits [12c+11:12c] of the sample and gain buses, and the gain is unsigned with 8 fractional bits. A channel counts as hit only when its corrected value is strictly greater than `low_thr_i`.
- R3: `mult_o` equals the number of hit channels among the samples taken two rising edges earlier, and it never exceeds 9.
- R4: A Cherenkov candidate needs two things: the hit count is at least `min_mult_i`, with a setting of 0 treated as 1, and the sum of all nine corrected values is strictly greater than `sum_thr_i`.
- R5: A corrected value that would exceed 4095 is clamped to 4095 before it is compared and summed.
- R6: A candidate and a calorimeter hit whose input samples lie at most `win_ticks_i` cycles apart, in either order, produce a trigger. The pulse appears three rising edges after the later of the two is sampled.
- R7: A candidate and a calorimeter hit more than `win_ticks_i` cycles apart produce no trigger. A setting of 0 requires both in the same cycle.
- R8: `trig_o` is never high for two consecutive cycles.
- R9: After a pulse, `trig_o` stays low for at least `holdoff_i`+1 cycles, and coincidences inside that span are dropped. Under a continuous coincidence, pulses repeat exactly `holdoff_i`+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pmt_samples_i | input | 108 | Nine 12-bit tube amplitudes, channel c at [12c+11:12c] |
| pmt_gain_i | input | 108 | Nine 12-bit gain factors (8 fractional bits), same packing |
| low_thr_i | input | 12 | Per-channel hit threshold |
| sum_thr_i | input | 16 | Threshold for the corrected sum |
| min_mult_i | input | 4 | Minimum number of hit tubes (0 acts as 1) |
| win_ticks_i | input | 4 | Coincidence half-window in clock cycles |
| holdoff_i | input | 8 | Dead span after a trigger, in cycles |
| calo_hit_i | input | 1 | Calorimeter hit flag for this sector |
| trig_o | output | 1 | Single-cycle trigger pulse |
| mult_o | output | 4 | Number of tubes above the low threshold |

## Verification
The bound checker looks at every cycle and covers four things: the pulse shape, the minimum spacing between pulses against the hold-off setting, the bound on the multiplicity, and the cleared outputs after reset. The bench's scenarios cover the rest. These are the exact gain arithmetic and its clamp, the strict thresholds, and the joint condition of multiplicity and sum. They also include the early and late calorimeter offsets at and just past the window edge, the latency of the pulse, and the exact repeat period under a sustained coincidence.

// File: rtl/pmt_trig_pkg.sv
// Shared sizing for the sector Cherenkov trigger.
// Assumes the nine tube channels share one sample width and one gain format.
package pmt_trig_pkg;
    localparam int unsigned DEF_N_CH      = 9;
    localparam int unsigned DEF_SAMPLE_W  = 12;
    localparam int unsigned DEF_GAIN_W    = 12;
    localparam int unsigned DEF_GAIN_FRAC = 8;
    localparam int unsigned DEF_WIN_W     = 4;
    localparam int unsigned DEF_HOLD_W    = 8;
    // Pipeline stages between the sample inputs and the candidate flag.
    localparam int unsigned CAND_LAT      = 2;

    // Width needed to count 0..n.
    function automatic int unsigned count_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/pmt_gain_stage.sv
// Applies one tube's gain correction and registers the result.
// Assumes an unsigned gain with GAIN_FRAC fractional bits. The result is
// clamped to the largest SAMPLE_W value instead of wrapping.
module pmt_gain_stage #(
    parameter int unsigned SAMPLE_W  = 12,
    parameter int unsigned GAIN_W    = 12,
    parameter int unsigned GAIN_FRAC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [GAIN_W-1:0]   gain_i,
    output logic [SAMPLE_W-1:0] corr_o
);
    localparam int unsigned PROD_W = SAMPLE_W + GAIN_W;

    logic [PROD_W-1:0]   prod;
    logic [PROD_W-1:0]   scaled;
    logic [SAMPLE_W-1:0] clamped;

    // Full-precision product, fraction dropped, then clamp to the sample range.
    always_comb begin
        prod    = {{GAIN_W{1'b0}}, sample_i} * {{SAMPLE_W{1'b0}}, gain_i};
        scaled  = prod >> GAIN_FRAC;
        if (|scaled[PROD_W-1:SAMPLE_W]) begin
            clamped = {SAMPLE_W{1'b1}};
        end else begin
            clamped = scaled[SAMPLE_W-1:0];
        end
    end

    // Register the corrected amplitude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_o <= '0;
        end else begin
            corr_o <= clamped;
        end
    end
endmodule

// File: rtl/pmt_hit_sum.sv
// Counts tubes above the low threshold and sums all corrected amplitudes.
// Raises the candidate flag when both the multiplicity test and the sum test
// pass. Assumes the corrected values arrive packed, channel 0 in the low bits.
module pmt_hit_sum #(
    parameter int unsigned N_CH     = 9,
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned MULT_W   = 4,
    parameter int unsigned SUM_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*SAMPLE_W-1:0] corr_i,
    input  logic [SAMPLE_W-1:0]      low_thr_i,
    input  logic [SUM_W-1:0]         sum_thr_i,
    input  logic [MULT_W-1:0]        min_mult_i,
    output logic [MULT_W-1:0]        mult_o,
    output logic                     cand_o
);
    logic [N_CH-1:0]   hit;
    logic [MULT_W-1:0] cnt_c;
    logic [SUM_W-1:0]  sum_c;
    logic [MULT_W-1:0] eff_min;
    logic              mult_ok;
    logic              sum_ok;

    // Per-channel strict comparison against the low threshold.
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            hit[c] = corr_i[c*SAMPLE_W +: SAMPLE_W] > low_thr_i;
        end
    end

    // Population count of hits and the sum of corrected amplitudes.
    always_comb begin
        cnt_c = '0;
        sum_c = '0;
        for (int c = 0; c < N_CH; c++) begin
            cnt_c = cnt_c + {{(MULT_W-1){1'b0}}, hit[c]};
            sum_c = sum_c + {{(SUM_W-SAMPLE_W){1'b0}}, corr_i[c*SAMPLE_W +: SAMPLE_W]};
        end
    end

    // Both tests; a minimum multiplicity of zero is raised to one.
    always_comb begin
        eff_min = (min_mult_i == '0) ? {{(MULT_W-1){1'b0}}, 1'b1} : min_mult_i;
        mult_ok = cnt_c >= eff_min;
        sum_ok  = sum_c > sum_thr_i;
    end

    // Register the multiplicity and the candidate flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_o <= '0;
            cand_o <= 1'b0;
        end else begin
            mult_o <= cnt_c;
            cand_o <= mult_ok && sum_ok;
        end
    end
endmodule

// File: rtl/coinc_window.sv
// Symmetric time coincidence of two event flags, with a hold-off on the result.
// Each side keeps a countdown. An event reloads it with the window setting,
// so a partner up to win_i cycles later still matches. A trigger loads the
// hold-off counter with holdoff_i+1, and triggers stay blocked until it
// reaches zero. Assumes both flags are already aligned to the same timebase.
module coinc_window #(
    parameter int unsigned WIN_W  = 4,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_i,
    input  logic              calo_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              trig_o
);
    logic [WIN_W-1:0]  cand_cnt;
    logic [WIN_W-1:0]  calo_cnt;
    logic [HOLD_W:0]   hold_cnt;
    logic              cand_recent;
    logic              calo_recent;
    logic              match;
    logic              fire;

    // Match now, or against a partner seen within the window in either order.
    always_comb begin
        cand_recent = cand_cnt != '0;
        calo_recent = calo_cnt != '0;
        match = (cand_i && (calo_i || calo_recent)) || (calo_i && cand_recent);
        fire  = match && (hold_cnt == '0);
    end

    // Window countdown started by a candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_cnt <= '0;
        end else if (cand_i) begin
            cand_cnt <= win_i;
        end else if (cand_cnt != '0) begin
            cand_cnt <= cand_cnt - {{(WIN_W-1){1'b0}}, 1'b1};
        end
    end

    // Window countdown started by a calorimeter hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calo_cnt <= '0;
        end else if (calo_i) begin
            calo_cnt <= win_i;
        end else if (calo_cnt != '0) begin
            calo_cnt <= calo_cnt - {{(WIN_W-1){1'b0}}, 1'b1};
        end
    end

    // Hold-off countdown, started by the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (fire) begin
            hold_cnt <= {1'b0, holdoff_i} + {{HOLD_W{1'b0}}, 1'b1};
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - {{HOLD_W{1'b0}}, 1'b1};
        end
    end

    // Register the trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
        end else begin
            trig_o <= fire;
        end
    end
endmodule

// File: rtl/pmt_coinc_trigger.sv
// Sector Cherenkov trigger. Per-tube gain correction (one stage), then the
// multiplicity and sum tests (one stage), then the calorimeter coincidence
// (one stage). The calorimeter flag is delayed to line up with the candidate.
// Assumes the configuration inputs are static while triggers are expected.
module pmt_coinc_trigger
    import pmt_trig_pkg::*;
#(
    parameter int unsigned N_CH      = DEF_N_CH,
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
    parameter int unsigned GAIN_W    = DEF_GAIN_W,
    parameter int unsigned GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int unsigned WIN_W     = DEF_WIN_W,
    parameter int unsigned HOLD_W    = DEF_HOLD_W,
    localparam int unsigned MULT_W   = count_w(N_CH),
    localparam int unsigned SUM_W    = SAMPLE_W + $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*SAMPLE_W-1:0] pmt_samples_i,
    input  logic [N_CH*GAIN_W-1:0]   pmt_gain_i,
    input  logic [SAMPLE_W-1:0]      low_thr_i,
    input  logic [SUM_W-1:0]         sum_thr_i,
    input  logic [MULT_W-1:0]        min_mult_i,
    input  logic [WIN_W-1:0]         win_ticks_i,
    input  logic [HOLD_W-1:0]        holdoff_i,
    input  logic                     calo_hit_i,
    output logic                     trig_o,
    output logic [MULT_W-1:0]        mult_o
);
    logic [N_CH*SAMPLE_W-1:0] corr;
    logic                     cand;
    logic [CAND_LAT-1:0]      calo_dly;

    // One gain stage per tube.
    for (genvar c = 0; c < N_CH; c++) begin : g_gain
        pmt_gain_stage #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_W   (GAIN_W),
            .GAIN_FRAC(GAIN_FRAC)
        ) gain_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample_i(pmt_samples_i[c*SAMPLE_W +: SAMPLE_W]),
            .gain_i  (pmt_gain_i[c*GAIN_W +: GAIN_W]),
            .corr_o  (corr[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    pmt_hit_sum #(
        .N_CH    (N_CH),
        .SAMPLE_W(SAMPLE_W),
        .MULT_W  (MULT_W),
        .SUM_W   (SUM_W)
    ) hits_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .corr_i    (corr),
        .low_thr_i (low_thr_i),
        .sum_thr_i (sum_thr_i),
        .min_mult_i(min_mult_i),
        .mult_o    (mult_o),
        .cand_o    (cand)
    );

    // Delay the calorimeter flag by the candidate pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calo_dly <= '0;
        end else begin
            calo_dly <= {calo_dly[CAND_LAT-2:0], calo_hit_i};
        end
    end

    coinc_window #(
        .WIN_W (WIN_W),
        .HOLD_W(HOLD_W)
    ) coinc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand_i   (cand),
        .calo_i   (calo_dly[CAND_LAT-1]),
        .win_i    (win_ticks_i),
        .holdoff_i(holdoff_i),
        .trig_o   (trig_o)
    );
endmodule

// File: rtl/pmt_coinc_trigger_chk.sv
// Cycle-by-cycle checks on the trigger outputs. It is bound into every
// instance of the top module and keeps its own spacing counter for the
// hold-off check.
module pmt_coinc_trigger_chk #(
    parameter int unsigned N_CH   = 9,
    parameter int unsigned MULT_W = 4,
    parameter int unsigned HOLD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_o,
    input logic [MULT_W-1:0] mult_o,
    input logic [HOLD_W-1:0] holdoff_i
);
    localparam int unsigned GAP_W = HOLD_W + 2;

    logic [GAP_W-1:0] gap_cnt;
    logic             seen_trig;

    // Cycles since the last pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt   <= '0;
            seen_trig <= 1'b0;
        end else if (trig_o) begin
            gap_cnt   <= {{(GAP_W-1){1'b0}}, 1'b1};
            seen_trig <= 1'b1;
        end else if (gap_cnt != {GAP_W{1'b1}}) begin
            gap_cnt   <= gap_cnt + {{(GAP_W-1){1'b0}}, 1'b1};
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!trig_o && mult_o == '0));

    // R3
    mult_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mult_o <= MULT_W'(N_CH));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R9
    holdoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && seen_trig) |-> (gap_cnt >= {2'b00, holdoff_i} + GAP_W'(2)));
endmodule

bind pmt_coinc_trigger pmt_coinc_trigger_chk #(
    .N_CH  (N_CH),
    .MULT_W(MULT_W),
    .HOLD_W(HOLD_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_o   (trig_o),
    .mult_o   (mult_o),
    .holdoff_i(holdoff_i)
);

// File: tb/pmt_coinc_trigger_tb_top.sv
`timescale 1ns/1ps
module pmt_coinc_trigger_tb_top;
    localparam int N_CH = 9;
    localparam int SW   = 12;
    localparam int GW   = 12;
    localparam int MW   = 4;
    localparam int SUMW = 16;

    // Vector fields: {mask[8:0], amp[11:0], calo, exp_mult[3:0], exp_trig}
    localparam logic [26:0] VEC [8] = '{
        {9'h007, 12'd200, 1'b1, 4'd3, 1'b1},
        {9'h001, 12'd900, 1'b1, 4'd1, 1'b0},
        {9'h003, 12'd200, 1'b1, 4'd2, 1'b0},
        {9'h003, 12'd300, 1'b1, 4'd2, 1'b1},
        {9'h1FF, 12'd100, 1'b1, 4'd0, 1'b0},
        {9'h1FF, 12'd101, 1'b1, 4'd9, 1'b1},
        {9'h00F, 12'd300, 1'b0, 4'd4, 1'b0},
        {9'h000, 12'd0,   1'b1, 4'd0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CH*SW-1:0] pmt_samples_i = '0;
    logic [N_CH*GW-1:0] pmt_gain_i = '0;
    logic [SW-1:0]     low_thr_i = 12'd100;
    logic [SUMW-1:0]   sum_thr_i = 16'd500;
    logic [MW-1:0]     min_mult_i = 4'd2;
    logic [3:0]        win_ticks_i = 4'd2;
    logic [7:0]        holdoff_i = 8'd3;
    logic              calo_hit_i = 1'b0;
    logic              trig_o;
    logic [MW-1:0]     mult_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmt_coinc_trigger dut_i (
        .clk(clk), .rst_n(rst_n),
        .pmt_samples_i(pmt_samples_i), .pmt_gain_i(pmt_gain_i),
        .low_thr_i(low_thr_i), .sum_thr_i(sum_thr_i),
        .min_mult_i(min_mult_i), .win_ticks_i(win_ticks_i),
        .holdoff_i(holdoff_i), .calo_hit_i(calo_hit_i),
        .trig_o(trig_o), .mult_o(mult_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] mask, input logic [11:0] amp, input logic calo);
        for (int c = 0; c < N_CH; c++) begin
            pmt_samples_i[c*SW +: SW] = mask[c] ? amp : 12'd0;
        end
        calo_hit_i = calo;
    endtask

    task automatic idle(input int n);
        drive(9'h000, 12'd0, 1'b0);
        repeat (n) step();
    endtask

    task automatic set_unity_gain();
        for (int c = 0; c < N_CH; c++) pmt_gain_i[c*GW +: GW] = 12'd256;
    endtask

    // One sample cycle of stimulus; check multiplicity then trigger.
    task automatic shot(input logic [8:0] mask, input logic [11:0] amp, input logic calo,
                        input int exp_mult, input int exp_trig, input string rm, input string rt);
        drive(mask, amp, calo);
        step();
        drive(9'h000, 12'd0, 1'b0);
        step();
        chk(rm, int'(mult_o), exp_mult);
        step();
        chk(rt, int'(trig_o), exp_trig);
        idle(8);
    endtask

    // Candidate at cycle ca, calorimeter at cycle cl; returns first pulse and count.
    task automatic pair(input int ca, input int cl, input int exp_first, input string req);
        int first = -1;
        int pulses = 0;
        for (int t = 0; t < 16; t++) begin
            drive((t == ca) ? 9'h007 : 9'h000, 12'd300, t == cl);
            step();
            if (trig_o) begin
                pulses++;
                if (first < 0) first = t;
            end
        end
        chk(req, first, exp_first);
        chk(req, pulses, (exp_first < 0) ? 0 : 1);
        idle(6);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [8:0]  m;
        logic [11:0] a;
        logic        c;
        logic [3:0]  em;
        logic        et;
        set_unity_gain();
        repeat (3) step();
        // R1: outputs cleared under reset
        chk("R1 trig", int'(trig_o), 0);
        chk("R1 mult", int'(mult_o), 0);
        rst_n = 1'b1;
        step();

        // Table walk: R3 multiplicity, R4/R6 candidate with aligned calorimeter
        for (int v = 0; v < 8; v++) begin
            {m, a, c, em, et} = VEC[v];
            shot(m, a, c, int'(em), int'(et), $sformatf("R3 vec%0d", v), $sformatf("R4 vec%0d", v));
        end

        // R2: 2.0 gain lifts 60 to 120 (hit); 0.5 gain drops 180 to 90 (miss)
        pmt_gain_i[0*GW +: GW] = 12'd512;
        pmt_gain_i[1*GW +: GW] = 12'd128;
        drive(9'h000, 12'd0, 1'b0);
        pmt_samples_i[0*SW +: SW] = 12'd60;
        pmt_samples_i[1*SW +: SW] = 12'd180;
        step();
        drive(9'h000, 12'd0, 1'b0);
        step();
        chk("R2 gain", int'(mult_o), 1);
        idle(8);

        // R5: saturated products sum to 8190
        pmt_gain_i[0*GW +: GW] = 12'hFFF;
        pmt_gain_i[1*GW +: GW] = 12'hFFF;
        sum_thr_i = 16'd8190;
        shot(9'h003, 12'd4095, 1'b1, 2, 0, "R5 mult", "R5 at-limit");
        sum_thr_i = 16'd8189;
        shot(9'h003, 12'd4095, 1'b1, 2, 1, "R5 mult", "R5 below-limit");
        sum_thr_i = 16'd500;
        set_unity_gain();

        // R4: min multiplicity 0 acts as 1
        min_mult_i = 4'd0;
        shot(9'h001, 12'd600, 1'b1, 1, 1, "R4 mult", "R4 min0");
        min_mult_i = 4'd2;

        // R6/R7: window of 2 ticks, both orders
        pair(0, 0, 2, "R6 same");
        pair(0, 2, 4, "R6 calo-late");
        pair(2, 0, 4, "R6 calo-early");
        pair(0, 3, -1, "R7 calo-late");
        pair(3, 0, -1, "R7 calo-early");
        win_ticks_i = 4'd0;
        pair(0, 0, 2, "R7 win0 same");
        pair(0, 1, -1, "R7 win0 off");
        win_ticks_i = 4'd2;

        // R8/R9: sustained coincidence, pulses at 2, 7, 12
        begin
            int n = 0;
            int prev = -100;
            int adj = 0;
            int gap_ok = 1;
            for (int t = 0; t < 30; t++) begin
                if (t <= 11) drive(9'h007, 12'd300, 1'b1);
                else drive(9'h000, 12'd0, 1'b0);
                step();
                if (trig_o) begin
                    if (t == prev + 1) adj++;
                    if (prev >= 0 && (t - prev) != 5) gap_ok = 0;
                    if (n == 0) chk("R9 first", t, 2);
                    n++;
                    prev = t;
                end
            end
            chk("R9 count", n, 3);
            chk("R9 spacing", gap_ok, 1);
            chk("R8 adjacent", adj, 0);
        end

        // R1: reset in mid-activity clears both outputs
        drive(9'h007, 12'd300, 1'b1);
        step();
        step();
        rst_n = 1'b0;
        step();
        chk("R1 mid trig", int'(trig_o), 0);
        chk("R1 mid mult", int'(mult_o), 0);
        rst_n = 1'b1;
        idle(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule